// File: doc/BRIEF.md
# Message and Doorbell Interrupt Unit

This block is the mailbox between a local CPU and a remote bus agent. Each party has its own simple register port (address, write data, write strobe, read strobe, read data) into one shared set of registers. There are two 32-bit message registers in each direction, one 32-bit doorbell in each direction, and one interrupt cause and mask register pair for each direction. Writing a message or ringing a doorbell sets a cause bit. Cause bits that are not masked drive a registered interrupt line toward the receiving party.

Only the receiving party can clear a notification. The CPU clears inbound message causes and inbound doorbell bits. The remote agent clears outbound message causes and outbound doorbell bits. The doorbell cause bit is the OR of all bits in its doorbell, so its interrupt stays up until the last bit is cleared. A separate one-cycle event input lets a neighbouring queue engine flag a pending inbound post. The CPU owns both mask registers. The remote agent can only read them.

Top module: `msg_doorbell_unit`

Both ports use the same word-offset map:

| Offset | Register |
|---|---|
| 0 | inbound message 0 |
| 1 | inbound message 1 |
| 2 | outbound message 0 |
| 3 | outbound message 1 |
| 4 | inbound doorbell |
| 5 | outbound doorbell |
| 6 | inbound cause |
| 7 | inbound mask |
| 8 | outbound cause |
| 9 | outbound mask |

Cause and mask bits: bit 0 is message 0, bit 1 is message 1, bit 2 is doorbell pending, bit 4 is inbound post event. Bit 3 is not used.

## Requirements
- R1: After a synchronous active-low reset, messages, doorbells and cause bits read 0, both masks (offsets 7 and 9) read 0x1F, and both interrupt outputs are 0.
- R2: A remote write to offset 0 or 1 stores the data, which the CPU reads back at that offset, and sets inbound cause bit 0 or 1 (offset 6).
- R3: A CPU write to offset 2 or 3 stores the data, which the remote reads back at that offset, and sets outbound cause bit 0 or 1 (offset 8).
- R4: A CPU write to offset 6 clears each inbound cause bit 0, 1 and 4 where the write data holds a 1. Zero bits leave the cause unchanged, and remote writes to offset 6 have no effect.
- R5: Outbound cause bits 0 and 1 are cleared only by remote writes of 1 to offset 8. CPU writes to offset 8 have no effect.
- R6: A CPU write to offset 5 sets the outbound doorbell bits that are 1 in the data and never clears any. A remote write of 1s to offset 5 clears those bits. Outbound cause bit 2 is 1 while any outbound doorbell bit is 1.
- R7: A remote write to offset 4 sets inbound doorbell bits. A CPU write of 1s to offset 4 clears them. Inbound cause bit 2 is 1 while any inbound doorbell bit is 1, and writing offset 6 does not clear it.
- R8: A mask bit at 1 keeps its cause bit from raising the interrupt, but the cause bit still latches and reads back. The CPU writes offset 7 (inbound mask) and offset 9 (outbound mask).
- R9: `cpu_irq` is the OR of inbound (cause AND NOT mask) over bits 0, 1, 2 and 4, and `rmt_irq` is the same over outbound bits 0, 1 and 2. Each is registered, so it changes one clock after the cause or mask changes.
- R10: When a set and a clear hit the same cause or doorbell bit in the same cycle, the bit ends up set.
- R11: A one-cycle pulse on `post_evt` sets inbound cause bit 4.
- R12: Read data is 0 while the read strobe is low, and offsets 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 4 | CPU word offset |
| cpu_wdata | input | 32 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_rdata | output | 32 | CPU read data, combinational |
| rmt_addr | input | 4 | Remote word offset |
| rmt_wdata | input | 32 | Remote write data |
| rmt_we | input | 1 | Remote write strobe |
| rmt_re | input | 1 | Remote read strobe |
| rmt_rdata | output | 32 | Remote read data, combinational |
| post_evt | input | 1 | Inbound post event pulse |
| cpu_irq | output | 1 | Interrupt toward the CPU |
| rmt_irq | output | 1 | Interrupt toward the remote agent |

## Verification
The bench targets the cases where ownership could leak. These are a CPU write clearing an outbound cause, a remote write clearing an inbound cause, a zero bit in a write-one-to-clear pattern, and a write to the cause register trying to drop the doorbell summary bit. A design that got any of these wrong would lose a notification before the receiving party had seen it. The bench also checks a doorbell with two bits set: its cause must stay set after one bit is cleared, or an interrupt would end early. It drives a set and a clear into the same bit in the same cycle and expects the set to survive. It checks that a masked cause still latches and that the interrupt moves exactly one clock after its cause. An early interrupt, or one a cycle late, fails at the sampled cycle.

// File: rtl/mdb_pkg.sv
// Package: shared constants for the message and doorbell unit.
// Assumes exactly two message registers per direction, matching the fixed map.
package mdb_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int NUM_MSG    = 2;
    localparam int CAUSE_W    = 5;

    typedef logic [REG_ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t A_IN_MSG0    = 4'd0;
    localparam reg_addr_t A_OUT_MSG0   = 4'd2;
    localparam reg_addr_t A_IN_DB      = 4'd4;
    localparam reg_addr_t A_OUT_DB     = 4'd5;
    localparam reg_addr_t A_IN_CAUSE   = 4'd6;
    localparam reg_addr_t A_IN_MASK    = 4'd7;
    localparam reg_addr_t A_OUT_CAUSE  = 4'd8;
    localparam reg_addr_t A_OUT_MASK   = 4'd9;

    localparam int CB_DB   = 2;
    localparam int CB_POST = 4;

    // Cause bits allowed to raise each interrupt line.
    localparam logic [CAUSE_W-1:0] IN_IRQ_SEL  = 5'b10111;
    localparam logic [CAUSE_W-1:0] OUT_IRQ_SEL = 5'b00111;

endpackage

// File: rtl/mdb_sticky_bits.sv
// Module: a vector of flags with per-bit set and clear inputs.
// Assumes set has priority over clear in the same cycle; resets to zero.
module mdb_sticky_bits #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    // Update flags: clear first, then apply sets so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

endmodule

// File: rtl/mdb_msg_bank.sv
// Module: a bank of message words, each loaded by its own write enable.
// Assumes one writer per bank; resets every word to zero.
module mdb_msg_bank #(
    parameter int NUM = 2,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM-1:0]  wr_en_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [NUM*DW-1:0] q_o
);

    for (genvar g = 0; g < NUM; g++) begin : g_word
        logic [DW-1:0] word_q;

        // Hold one message word, loading it on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en_i[g]) begin
                word_q <= wdata_i;
            end
        end

        assign q_o[g*DW +: DW] = word_q;
    end

endmodule

// File: rtl/mdb_irq_gen.sv
// Module: registered interrupt from cause and mask vectors.
// Assumes only bits set in SEL may raise the line; one cycle of latency.
module mdb_irq_gen #(
    parameter int          W   = 5,
    parameter logic [W-1:0] SEL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    logic pending;

    // Combine unmasked, selected cause bits.
    always_comb begin
        pending = |(cause_i & ~mask_i & SEL);
    end

    // Register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= pending;
        end
    end

endmodule

// File: rtl/mdb_read_mux.sv
// Module: read data selection for one access port over the shared map.
// Assumes the fixed offset map of the package; outputs zero without a read strobe.
module mdb_read_mux
    import mdb_pkg::*;
#(
    parameter int DW = 32
) (
    input  reg_addr_t              addr_i,
    input  logic                   re_i,
    input  logic [NUM_MSG*DW-1:0]  in_msg_i,
    input  logic [NUM_MSG*DW-1:0]  out_msg_i,
    input  logic [DW-1:0]          in_db_i,
    input  logic [DW-1:0]          out_db_i,
    input  logic [CAUSE_W-1:0]     in_cause_i,
    input  logic [CAUSE_W-1:0]     in_mask_i,
    input  logic [CAUSE_W-1:0]     out_cause_i,
    input  logic [CAUSE_W-1:0]     out_mask_i,
    output logic [DW-1:0]          rdata_o
);

    localparam int PAD_W = DW - CAUSE_W;

    // Select the addressed register, or zero.
    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            case (addr_i)
                4'd0:        rdata_o = in_msg_i[0 +: DW];
                4'd1:        rdata_o = in_msg_i[DW +: DW];
                4'd2:        rdata_o = out_msg_i[0 +: DW];
                4'd3:        rdata_o = out_msg_i[DW +: DW];
                A_IN_DB:     rdata_o = in_db_i;
                A_OUT_DB:    rdata_o = out_db_i;
                A_IN_CAUSE:  rdata_o = {{PAD_W{1'b0}}, in_cause_i};
                A_IN_MASK:   rdata_o = {{PAD_W{1'b0}}, in_mask_i};
                A_OUT_CAUSE: rdata_o = {{PAD_W{1'b0}}, out_cause_i};
                A_OUT_MASK:  rdata_o = {{PAD_W{1'b0}}, out_mask_i};
                default:     rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/msg_doorbell_unit.sv
// Module: mailbox and doorbell registers shared by a local CPU and a remote agent.
// Assumes both ports act in the same clock domain. Each notification is cleared
// only by its receiver, and set beats clear when both hit one bit in a cycle.
module msg_doorbell_unit
    import mdb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic                  cpu_we,
    input  logic                  cpu_re,
    output logic [DATA_W-1:0]     cpu_rdata,
    input  logic [REG_ADDR_W-1:0] rmt_addr,
    input  logic [DATA_W-1:0]     rmt_wdata,
    input  logic                  rmt_we,
    input  logic                  rmt_re,
    output logic [DATA_W-1:0]     rmt_rdata,
    input  logic                  post_evt,
    output logic                  cpu_irq,
    output logic                  rmt_irq
);

    logic [NUM_MSG-1:0]        in_msg_wr;
    logic [NUM_MSG-1:0]        out_msg_wr;
    logic [NUM_MSG*DATA_W-1:0] in_msg_q;
    logic [NUM_MSG*DATA_W-1:0] out_msg_q;

    logic cpu_wr_in_cause, cpu_wr_in_db, cpu_wr_out_db;
    logic cpu_wr_in_mask, cpu_wr_out_mask;
    logic rmt_wr_out_cause, rmt_wr_in_db, rmt_wr_out_db;

    logic [NUM_MSG-1:0] in_msg_clr, out_msg_clr;
    logic [NUM_MSG-1:0] in_msg_cause_q, out_msg_cause_q;
    logic               post_clr, post_q;
    logic [DATA_W-1:0]  in_db_set, in_db_clr, in_db_q;
    logic [DATA_W-1:0]  out_db_set, out_db_clr, out_db_q;
    logic [CAUSE_W-1:0] in_mask_q, out_mask_q;
    logic [CAUSE_W-1:0] in_cause_view, out_cause_view;

    // Per-message write enables from each owner port.
    for (genvar g = 0; g < NUM_MSG; g++) begin : g_msg_dec
        assign in_msg_wr[g]  = rmt_we && (rmt_addr == reg_addr_t'(A_IN_MSG0 + g));
        assign out_msg_wr[g] = cpu_we && (cpu_addr == reg_addr_t'(A_OUT_MSG0 + g));
    end

    // Decode the remaining register writes of both ports.
    always_comb begin
        cpu_wr_in_cause  = cpu_we && (cpu_addr == A_IN_CAUSE);
        cpu_wr_in_db     = cpu_we && (cpu_addr == A_IN_DB);
        cpu_wr_out_db    = cpu_we && (cpu_addr == A_OUT_DB);
        cpu_wr_in_mask   = cpu_we && (cpu_addr == A_IN_MASK);
        cpu_wr_out_mask  = cpu_we && (cpu_addr == A_OUT_MASK);
        rmt_wr_out_cause = rmt_we && (rmt_addr == A_OUT_CAUSE);
        rmt_wr_in_db     = rmt_we && (rmt_addr == A_IN_DB);
        rmt_wr_out_db    = rmt_we && (rmt_addr == A_OUT_DB);
    end

    // Build write-one-to-clear and write-one-to-set patterns.
    always_comb begin
        in_msg_clr  = cpu_wr_in_cause  ? cpu_wdata[NUM_MSG-1:0] : '0;
        post_clr    = cpu_wr_in_cause  && cpu_wdata[CB_POST];
        out_msg_clr = rmt_wr_out_cause ? rmt_wdata[NUM_MSG-1:0] : '0;
        in_db_set   = rmt_wr_in_db  ? rmt_wdata : '0;
        in_db_clr   = cpu_wr_in_db  ? cpu_wdata : '0;
        out_db_set  = cpu_wr_out_db ? cpu_wdata : '0;
        out_db_clr  = rmt_wr_out_db ? rmt_wdata : '0;
    end

    mdb_msg_bank #(.NUM(NUM_MSG), .DW(DATA_W)) u_in_msg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(in_msg_wr),
        .wdata_i(rmt_wdata), .q_o(in_msg_q)
    );

    mdb_msg_bank #(.NUM(NUM_MSG), .DW(DATA_W)) u_out_msg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(out_msg_wr),
        .wdata_i(cpu_wdata), .q_o(out_msg_q)
    );

    mdb_sticky_bits #(.W(NUM_MSG)) u_in_msg_cause (
        .clk(clk), .rst_n(rst_n), .set_i(in_msg_wr),
        .clr_i(in_msg_clr), .q_o(in_msg_cause_q)
    );

    mdb_sticky_bits #(.W(NUM_MSG)) u_out_msg_cause (
        .clk(clk), .rst_n(rst_n), .set_i(out_msg_wr),
        .clr_i(out_msg_clr), .q_o(out_msg_cause_q)
    );

    mdb_sticky_bits #(.W(1)) u_post_cause (
        .clk(clk), .rst_n(rst_n), .set_i(post_evt),
        .clr_i(post_clr), .q_o(post_q)
    );

    mdb_sticky_bits #(.W(DATA_W)) u_in_db (
        .clk(clk), .rst_n(rst_n), .set_i(in_db_set),
        .clr_i(in_db_clr), .q_o(in_db_q)
    );

    mdb_sticky_bits #(.W(DATA_W)) u_out_db (
        .clk(clk), .rst_n(rst_n), .set_i(out_db_set),
        .clr_i(out_db_clr), .q_o(out_db_q)
    );

    // Mask registers, owned by the CPU, reset to all masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mask_q  <= '1;
            out_mask_q <= '1;
        end else begin
            if (cpu_wr_in_mask)  in_mask_q  <= cpu_wdata[CAUSE_W-1:0];
            if (cpu_wr_out_mask) out_mask_q <= cpu_wdata[CAUSE_W-1:0];
        end
    end

    // Assemble cause views; the doorbell bit summarises the whole doorbell.
    always_comb begin
        in_cause_view  = {post_q, 1'b0, |in_db_q, in_msg_cause_q};
        out_cause_view = {1'b0, 1'b0, |out_db_q, out_msg_cause_q};
    end

    mdb_irq_gen #(.W(CAUSE_W), .SEL(IN_IRQ_SEL)) u_cpu_irq (
        .clk(clk), .rst_n(rst_n), .cause_i(in_cause_view),
        .mask_i(in_mask_q), .irq_o(cpu_irq)
    );

    mdb_irq_gen #(.W(CAUSE_W), .SEL(OUT_IRQ_SEL)) u_rmt_irq (
        .clk(clk), .rst_n(rst_n), .cause_i(out_cause_view),
        .mask_i(out_mask_q), .irq_o(rmt_irq)
    );

    mdb_read_mux #(.DW(DATA_W)) u_cpu_rd (
        .addr_i(cpu_addr), .re_i(cpu_re),
        .in_msg_i(in_msg_q), .out_msg_i(out_msg_q),
        .in_db_i(in_db_q), .out_db_i(out_db_q),
        .in_cause_i(in_cause_view), .in_mask_i(in_mask_q),
        .out_cause_i(out_cause_view), .out_mask_i(out_mask_q),
        .rdata_o(cpu_rdata)
    );

    mdb_read_mux #(.DW(DATA_W)) u_rmt_rd (
        .addr_i(rmt_addr), .re_i(rmt_re),
        .in_msg_i(in_msg_q), .out_msg_i(out_msg_q),
        .in_db_i(in_db_q), .out_db_i(out_db_q),
        .in_cause_i(in_cause_view), .in_mask_i(in_mask_q),
        .out_cause_i(out_cause_view), .out_mask_i(out_mask_q),
        .rdata_o(rmt_rdata)
    );

endmodule

// File: rtl/mdb_unit_chk.sv
// Module: protocol checks for the message and doorbell unit, bound to its top.
// Assumes the package offset map and cause bit layout.
module mdb_unit_chk
    import mdb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] cpu_addr,
    input logic                  cpu_we,
    input logic [REG_ADDR_W-1:0] rmt_addr,
    input logic                  rmt_we,
    input logic                  post_evt,
    input logic                  cpu_irq,
    input logic                  rmt_irq,
    input logic [CAUSE_W-1:0]    in_cause,
    input logic [CAUSE_W-1:0]    in_mask,
    input logic [CAUSE_W-1:0]    out_cause,
    input logic [CAUSE_W-1:0]    out_mask,
    input logic [DATA_W-1:0]     in_db,
    input logic [DATA_W-1:0]     out_db
);

    // R9: CPU interrupt follows last cycle's unmasked inbound causes.
    a_r9_cpu_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(|(in_cause & ~in_mask & IN_IRQ_SEL)));

    // R9: remote interrupt follows last cycle's unmasked outbound causes.
    a_r9_rmt_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_irq == $past(|(out_cause & ~out_mask & OUT_IRQ_SEL)));

    // R2: a remote message write leaves inbound cause bit 0 set.
    a_r2_in_msg0_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_we && rmt_addr == 4'd0) |=> in_cause[0]);

    // R11: a post event leaves inbound cause bit 4 set.
    a_r11_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        post_evt |=> in_cause[CB_POST]);

    // R4: inbound message cause bits fall only on a CPU cause write.
    a_r4_in_cause_clear_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(in_cause[1:0]) & ~in_cause[1:0]) != 2'b00)
        |-> ($past(cpu_we) && $past(cpu_addr) == A_IN_CAUSE));

    // R5: outbound message cause bits fall only on a remote cause write.
    a_r5_out_cause_clear_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(out_cause[1:0]) & ~out_cause[1:0]) != 2'b00)
        |-> ($past(rmt_we) && $past(rmt_addr) == A_OUT_CAUSE));

    // R7: inbound doorbell bits fall only on a CPU doorbell write.
    a_r7_in_db_clear_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(in_db) & ~in_db) != '0)
        |-> ($past(cpu_we) && $past(cpu_addr) == A_IN_DB));

    // R6: outbound doorbell bits fall only on a remote doorbell write.
    a_r6_out_db_clear_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(out_db) & ~out_db) != '0)
        |-> ($past(rmt_we) && $past(rmt_addr) == A_OUT_DB));

endmodule

bind msg_doorbell_unit mdb_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .rmt_addr(rmt_addr), .rmt_we(rmt_we),
    .post_evt(post_evt), .cpu_irq(cpu_irq), .rmt_irq(rmt_irq),
    .in_cause(in_cause_view), .in_mask(in_mask_q),
    .out_cause(out_cause_view), .out_mask(out_mask_q),
    .in_db(in_db_q), .out_db(out_db_q)
);

// File: tb/msg_doorbell_unit_tb.sv
module msg_doorbell_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_addr = '0, rmt_addr = '0;
    logic [31:0] cpu_wdata = '0, rmt_wdata = '0;
    logic        cpu_we = 1'b0, cpu_re = 1'b0, rmt_we = 1'b0, rmt_re = 1'b0;
    logic        post_evt = 1'b0;
    logic [31:0] cpu_rdata, rmt_rdata;
    logic        cpu_irq, rmt_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    msg_doorbell_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
        .rmt_addr(rmt_addr), .rmt_wdata(rmt_wdata), .rmt_we(rmt_we),
        .rmt_re(rmt_re), .rmt_rdata(rmt_rdata),
        .post_evt(post_evt), .cpu_irq(cpu_irq), .rmt_irq(rmt_irq)
    );

    typedef struct packed {
        logic        wr;
        logic        wside;   // 1 = remote port
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic        rside;   // 1 = remote port
        logic [3:0]  raddr;
        logic [31:0] rexp;
        logic        cirq;
        logic        rirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b1,4'd0,32'hA5A5_0001,1'b0,4'd0,32'hA5A5_0001,1'b0,1'b0,4'd2},  // R2
        '{1'b1,1'b1,4'd1,32'h1234_5678,1'b0,4'd1,32'h1234_5678,1'b0,1'b0,4'd2},  // R2
        '{1'b0,1'b0,4'd0,32'h0,        1'b0,4'd6,32'h3,        1'b0,1'b0,4'd2},  // R2
        '{1'b1,1'b0,4'd6,32'h1,        1'b0,4'd6,32'h2,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b0,4'd6,32'h0,        1'b0,4'd6,32'h2,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b1,4'd6,32'hFFFF_FFFF,1'b0,4'd6,32'h2,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b0,4'd6,32'h2,        1'b0,4'd6,32'h0,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b0,4'd3,32'hCAFE_F00D,1'b1,4'd3,32'hCAFE_F00D,1'b0,1'b0,4'd3},  // R3
        '{1'b0,1'b0,4'd0,32'h0,        1'b1,4'd8,32'h2,        1'b0,1'b0,4'd3},  // R3
        '{1'b1,1'b0,4'd8,32'hFF,       1'b1,4'd8,32'h2,        1'b0,1'b0,4'd5},  // R5
        '{1'b1,1'b1,4'd8,32'h2,        1'b1,4'd8,32'h0,        1'b0,1'b0,4'd5},  // R5
        '{1'b1,1'b0,4'd5,32'h81,       1'b1,4'd5,32'h81,       1'b0,1'b0,4'd6},  // R6
        '{1'b0,1'b0,4'd0,32'h0,        1'b1,4'd8,32'h4,        1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b0,4'd5,32'h0,        1'b1,4'd5,32'h81,       1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b1,4'd5,32'h1,        1'b1,4'd5,32'h80,       1'b0,1'b0,4'd6},  // R6
        '{1'b0,1'b0,4'd0,32'h0,        1'b1,4'd8,32'h4,        1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b1,4'd5,32'h80,       1'b1,4'd8,32'h0,        1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b1,4'd4,32'h300,      1'b0,4'd4,32'h300,      1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,4'd4,32'h100,      1'b0,4'd6,32'h4,        1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,4'd6,32'h4,        1'b0,4'd6,32'h4,        1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,4'd4,32'h200,      1'b0,4'd6,32'h0,        1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b1,4'd0,32'h5,        1'b0,4'd6,32'h1,        1'b0,1'b0,4'd8},  // R8
        '{1'b1,1'b0,4'd6,32'h1,        1'b0,4'd6,32'h0,        1'b0,1'b0,4'd8},  // R8
        '{1'b0,1'b0,4'd0,32'h0,        1'b0,4'd15,32'h0,       1'b0,1'b0,4'd12}  // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write on one port, then wait until a registered interrupt has settled.
    task automatic wr(input logic side, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (side) begin rmt_we = 1'b1; rmt_addr = a; rmt_wdata = d; end
        else      begin cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; end
        @(negedge clk);
        rmt_we = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
    endtask

    // Read on one port, sampling away from the clock edge.
    task automatic rd(input logic side, input logic [3:0] a, output logic [31:0] d);
        if (side) begin rmt_re = 1'b1; rmt_addr = a; end
        else      begin cpu_re = 1'b1; cpu_addr = a; end
        #2;
        d = side ? rmt_rdata : cpu_rdata;
        rmt_re = 1'b0; cpu_re = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        check("R1 rmt_irq", {31'b0, rmt_irq}, 32'h0);
        rd(1'b0, 4'd6, d); check("R1 in cause", d, 32'h0);
        rd(1'b0, 4'd7, d); check("R1 in mask", d, 32'h1F);
        rd(1'b0, 4'd9, d); check("R1 out mask", d, 32'h1F);
        rd(1'b0, 4'd4, d); check("R1 in doorbell", d, 32'h0);
        rd(1'b1, 4'd8, d); check("R1 out cause", d, 32'h0);
        rd(1'b1, 4'd2, d); check("R1 out msg0", d, 32'h0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) wr(VECS[i].wside, VECS[i].waddr, VECS[i].wdata);
            else @(negedge clk);
            rd(VECS[i].rside, VECS[i].raddr, d);
            check($sformatf("R%0d vector %0d read", VECS[i].req, i), d, VECS[i].rexp);
            check($sformatf("R%0d vector %0d cpu_irq", VECS[i].req, i), {31'b0, cpu_irq}, {31'b0, VECS[i].cirq});
            check($sformatf("R%0d vector %0d rmt_irq", VECS[i].req, i), {31'b0, rmt_irq}, {31'b0, VECS[i].rirq});
        end

        // R9: inbound interrupt rises and falls one clock after its cause
        wr(1'b0, 4'd7, 32'h0);
        @(negedge clk);
        rmt_we = 1'b1; rmt_addr = 4'd0; rmt_wdata = 32'h77;
        @(negedge clk);
        rmt_we = 1'b0;
        check("R9 cpu_irq not yet up", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R9 cpu_irq up", {31'b0, cpu_irq}, 32'h1);
        cpu_we = 1'b1; cpu_addr = 4'd6; cpu_wdata = 32'h1;
        @(negedge clk);
        cpu_we = 1'b0;
        check("R9 cpu_irq not yet down", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk);
        check("R9 cpu_irq down", {31'b0, cpu_irq}, 32'h0);

        // R11: post event raises inbound cause bit 4
        post_evt = 1'b1;
        @(negedge clk);
        post_evt = 1'b0;
        @(negedge clk);
        check("R11 cpu_irq from post", {31'b0, cpu_irq}, 32'h1);
        // R8: masking drops the line while the cause stays latched
        wr(1'b0, 4'd7, 32'h10);
        check("R8 cpu_irq masked", {31'b0, cpu_irq}, 32'h0);
        rd(1'b0, 4'd6, d); check("R8 cause latched while masked", d, 32'h10);
        wr(1'b0, 4'd7, 32'h0);
        wr(1'b0, 4'd6, 32'h10);
        rd(1'b0, 4'd6, d); check("R4 post cause cleared", d, 32'h0);

        // R10: set and clear on the same cycle, set wins
        @(negedge clk);
        post_evt = 1'b1; cpu_we = 1'b1; cpu_addr = 4'd6; cpu_wdata = 32'h10;
        @(negedge clk);
        post_evt = 1'b0; cpu_we = 1'b0;
        rd(1'b0, 4'd6, d); check("R10 cause set wins", d, 32'h10);
        wr(1'b0, 4'd6, 32'h10);
        @(negedge clk);
        rmt_we = 1'b1; rmt_addr = 4'd4; rmt_wdata = 32'h1;
        cpu_we = 1'b1; cpu_addr = 4'd4; cpu_wdata = 32'h1;
        @(negedge clk);
        rmt_we = 1'b0; cpu_we = 1'b0;
        rd(1'b0, 4'd4, d); check("R10 doorbell set wins", d, 32'h1);
        wr(1'b0, 4'd4, 32'h1);
        rd(1'b0, 4'd4, d); check("R7 doorbell cleared", d, 32'h0);

        // R9 / R3 / R5 / R6: remote-side interrupt
        wr(1'b0, 4'd9, 32'h0);
        check("R9 rmt_irq idle", {31'b0, rmt_irq}, 32'h0);
        wr(1'b0, 4'd2, 32'h5555_AAAA);
        check("R3 rmt_irq on out msg", {31'b0, rmt_irq}, 32'h1);
        wr(1'b0, 4'd8, 32'h1);
        check("R5 cpu cannot drop rmt_irq", {31'b0, rmt_irq}, 32'h1);
        wr(1'b1, 4'd8, 32'h1);
        check("R5 remote clear drops rmt_irq", {31'b0, rmt_irq}, 32'h0);
        wr(1'b0, 4'd5, 32'h4);
        check("R6 rmt_irq on doorbell", {31'b0, rmt_irq}, 32'h1);
        wr(1'b1, 4'd5, 32'h4);
        check("R6 rmt_irq after doorbell clear", {31'b0, rmt_irq}, 32'h0);

        // R12: no read strobe gives zero data
        @(negedge clk);
        cpu_addr = 4'd0; cpu_re = 1'b0;
        #2;
        check("R12 cpu_rdata without strobe", cpu_rdata, 32'h0);
        rd(1'b0, 4'd0, d); check("R2 in msg0 latest", d, 32'h77);

        summary();
        $finish;
    end

endmodule